// File: doc/BRIEF.md
# FIFO Status and Error Register Block

This block reports the state of a transmit and receive FIFO pair that sits between a DMA engine and a data path. The FIFOs stay outside the block. It receives the occupancy of each DMA-facing FIFO, the total transmit and receive occupancy, and two strobes. The receive total includes a short output pipeline. One strobe marks a write by the receive loader and the other marks a read by the transmit state machine. From these inputs it forms full and empty flags for each DMA FIFO. It also forms threshold flags from the totals, using two programmable levels.

Software reaches the block through a small register port that reads in the same cycle. Address 0 holds the status word. Address 1 holds the receive threshold level and address 2 the transmit threshold level. Address 3 returns the receive data count, which includes the pipeline and is meant for sizing reads. Two error bits record an overflow on the receive side and an underflow on the transmit side. Each stays set until software writes a one to it.

Top module: `fifo_stat_regs`

## Requirements
- R1: After reset, with both DMA FIFOs empty and both totals zero, address 0 reads 0x0013 and addresses 1 and 2 each read DEPTH/2 (8 by default).
- R2: Status bit 0 (Tx empty) is 1 exactly when the Tx DMA count is 0. Bit 2 (Tx full) is 1 exactly when the Tx DMA count equals DEPTH.
- R3: Status bit 4 (Rx empty) and bit 6 (Rx full) follow only the Rx DMA count, 0 and DEPTH respectively. Words held in the Rx pipeline do not affect them.
- R4: Status bit 5 (Rx almost-full) is 1 only when the Rx total count is strictly greater than the Rx level register.
- R5: Status bit 1 (Tx almost-empty) is 1 only when the Tx total count is strictly less than the Tx level register.
- R6: A loader write while the Rx DMA count equals DEPTH sets status bit 8 (Rx overflow) from the next cycle on. A loader write while the FIFO is not full leaves the bit clear. The bit then stays set.
- R7: A Tx state-machine read while the Tx DMA count is 0 sets status bit 9 (Tx underflow) from the next cycle on. The bit then stays set.
- R8: A register write to address 0 clears bit 8 or bit 9 in the next cycle when the matching write-data bit is 1. A 0 in that position leaves the bit unchanged.
- R9: If an error event and a clearing write for the same bit occur in the same cycle, the bit remains set.
- R10: Writes to address 1 (Rx level) and address 2 (Tx level) store the low TW write-data bits. Those bits read back, and the upper read bits are 0.
- R11: Address 3 returns the Rx total count, which includes the pipeline.
- R12: Status bits 3, 7 and 10 and above always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_dma_cnt | input | CW | Tx DMA FIFO occupancy |
| tx_total_cnt | input | TW | Total Tx occupancy |
| rx_dma_cnt | input | CW | Rx DMA FIFO occupancy |
| rx_total_cnt | input | TW | Rx FIFO plus pipeline occupancy |
| rx_load_wr | input | 1 | Receive loader writes the Rx FIFO |
| tx_sm_rd | input | 1 | Transmit state machine reads the Tx FIFO |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |

## Verification
The flag logic is driven with several count combinations. Some place each DMA FIFO empty while its total is nonzero, which separates DMA-based flags from total-based ones. Others set totals exactly at the threshold and one above or below it, which exposes a non-strict comparison. Full-and-empty pairs confirm the bit positions. Directed sequences cover the error bits: a strobe with the FIFO not full, a strobe with it full, a write of 0, a write of 1, and a clear that lands in the same cycle as an event. Together these separate sticky behaviour, write-one-to-clear behaviour and the priority of a new event over a clear.

// File: rtl/fss_pkg.sv
package fss_pkg;

  typedef enum logic [1:0] {
    ADR_STAT  = 2'd0,
    ADR_RXLVL = 2'd1,
    ADR_TXLVL = 2'd2,
    ADR_RXCNT = 2'd3
  } fss_addr_e;

  localparam int B_TX_EMPTY = 0;
  localparam int B_TX_AEMP  = 1;
  localparam int B_TX_FULL  = 2;
  localparam int B_RX_EMPTY = 4;
  localparam int B_RX_AFUL  = 5;
  localparam int B_RX_FULL  = 6;
  localparam int B_RX_OVF   = 8;
  localparam int B_TX_UNF   = 9;

endpackage

// File: rtl/fss_flags.sv
module fss_flags #(
  parameter int DEPTH = 16,
  parameter int CW    = 5,
  parameter int TW    = 6,
  parameter bit ABOVE = 1'b1
) (
  input  logic [CW-1:0] dma_cnt,
  input  logic [TW-1:0] tot_cnt,
  input  logic [TW-1:0] lvl,
  output logic          empty,
  output logic          full,
  output logic          thr
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  always_comb begin
    empty = (dma_cnt == '0);
    full  = (dma_cnt == FULL_CNT);
  end

  generate
    if (ABOVE) begin : g_above
      always_comb thr = (tot_cnt > lvl);
    end else begin : g_below
      always_comb thr = (tot_cnt < lvl);
    end
  endgenerate

endmodule

// File: rtl/fss_sticky.sv
module fss_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic q
);

  logic q_nxt;
  logic q_en;

  always_comb begin
    q_en  = evt | clr;
    q_nxt = evt ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (q_en) begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/fss_lvl_reg.sv
module fss_lvl_reg #(
  parameter int TW        = 6,
  parameter int RESET_VAL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [TW-1:0] wdata,
  output logic [TW-1:0] q
);

  logic [TW-1:0] q_nxt;

  always_comb q_nxt = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= TW'(RESET_VAL);
    end else if (wr_en) begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/fifo_stat_regs.sv
module fifo_stat_regs #(
  parameter int DEPTH = 16,
  parameter int PIPE  = 4,
  parameter int DW    = 16,
  localparam int CW   = $clog2(DEPTH) + 1,
  localparam int TW   = $clog2(DEPTH + PIPE) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] tx_dma_cnt,
  input  logic [TW-1:0] tx_total_cnt,
  input  logic [CW-1:0] rx_dma_cnt,
  input  logic [TW-1:0] rx_total_cnt,
  input  logic          rx_load_wr,
  input  logic          tx_sm_rd,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata
);
  import fss_pkg::*;

  localparam int LVL_RST = DEPTH / 2;

  logic tx_empty, tx_full, tx_aemp;
  logic rx_empty, rx_full, rx_aful;
  logic ovf_q, unf_q;
  logic ovf_evt, unf_evt, ovf_clr, unf_clr;
  logic stat_wr, rxlvl_wr, txlvl_wr;
  logic [TW-1:0] rx_lvl_q, tx_lvl_q;
  logic wdata_unused;

  assign wdata_unused = ^reg_wdata;

  always_comb begin
    stat_wr  = reg_wr && (fss_addr_e'(reg_addr) == ADR_STAT);
    rxlvl_wr = reg_wr && (fss_addr_e'(reg_addr) == ADR_RXLVL);
    txlvl_wr = reg_wr && (fss_addr_e'(reg_addr) == ADR_TXLVL);
    ovf_evt  = rx_load_wr && rx_full;
    unf_evt  = tx_sm_rd && tx_empty;
    ovf_clr  = stat_wr && reg_wdata[B_RX_OVF];
    unf_clr  = stat_wr && reg_wdata[B_TX_UNF];
  end

  fss_flags #(.DEPTH(DEPTH), .CW(CW), .TW(TW), .ABOVE(1'b0)) u_txf (
    .dma_cnt (tx_dma_cnt),
    .tot_cnt (tx_total_cnt),
    .lvl     (tx_lvl_q),
    .empty   (tx_empty),
    .full    (tx_full),
    .thr     (tx_aemp)
  );

  fss_flags #(.DEPTH(DEPTH), .CW(CW), .TW(TW), .ABOVE(1'b1)) u_rxf (
    .dma_cnt (rx_dma_cnt),
    .tot_cnt (rx_total_cnt),
    .lvl     (rx_lvl_q),
    .empty   (rx_empty),
    .full    (rx_full),
    .thr     (rx_aful)
  );

  fss_sticky u_ovf (
    .clk (clk), .rst_n (rst_n), .evt (ovf_evt), .clr (ovf_clr), .q (ovf_q)
  );

  fss_sticky u_unf (
    .clk (clk), .rst_n (rst_n), .evt (unf_evt), .clr (unf_clr), .q (unf_q)
  );

  fss_lvl_reg #(.TW(TW), .RESET_VAL(LVL_RST)) u_rxlvl (
    .clk (clk), .rst_n (rst_n), .wr_en (rxlvl_wr),
    .wdata (reg_wdata[TW-1:0]), .q (rx_lvl_q)
  );

  fss_lvl_reg #(.TW(TW), .RESET_VAL(LVL_RST)) u_txlvl (
    .clk (clk), .rst_n (rst_n), .wr_en (txlvl_wr),
    .wdata (reg_wdata[TW-1:0]), .q (tx_lvl_q)
  );

  always_comb begin
    reg_rdata = '0;
    case (fss_addr_e'(reg_addr))
      ADR_STAT: begin
        reg_rdata[B_TX_EMPTY] = tx_empty;
        reg_rdata[B_TX_AEMP]  = tx_aemp;
        reg_rdata[B_TX_FULL]  = tx_full;
        reg_rdata[B_RX_EMPTY] = rx_empty;
        reg_rdata[B_RX_AFUL]  = rx_aful;
        reg_rdata[B_RX_FULL]  = rx_full;
        reg_rdata[B_RX_OVF]   = ovf_q;
        reg_rdata[B_TX_UNF]   = unf_q;
      end
      ADR_RXLVL: reg_rdata[TW-1:0] = rx_lvl_q;
      ADR_TXLVL: reg_rdata[TW-1:0] = tx_lvl_q;
      ADR_RXCNT: reg_rdata[TW-1:0] = rx_total_cnt;
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/fss_chk.sv
module fss_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5,
  parameter int TW    = 6,
  parameter int DW    = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] rx_dma_cnt,
  input logic [CW-1:0] tx_dma_cnt,
  input logic          rx_load_wr,
  input logic          tx_sm_rd,
  input logic [1:0]    reg_addr,
  input logic          reg_wr,
  input logic [DW-1:0] reg_wdata,
  input logic          ovf_q,
  input logic          unf_q,
  input logic [TW-1:0] rx_lvl_q,
  input logic [TW-1:0] tx_lvl_q
);

  logic ovf_hit, unf_hit, swr;
  assign ovf_hit = rx_load_wr && (int'(rx_dma_cnt) == DEPTH);
  assign unf_hit = tx_sm_rd && (tx_dma_cnt == '0);
  assign swr     = reg_wr && (reg_addr == 2'd0);

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |=> ovf_q);

  // R7
  unf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_hit |=> unf_q);

  // R8
  ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swr && reg_wdata[8] && !ovf_hit) |=> !ovf_q);

  // R8
  unf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_q && !(swr && reg_wdata[9])) |=> unf_q);

  // R10
  rxlvl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=> (rx_lvl_q == $past(reg_wdata[TW-1:0])));

  // R10
  txlvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 2'd2) |=> $stable(tx_lvl_q));

endmodule

bind fifo_stat_regs fss_chk #(.DEPTH(DEPTH), .CW(CW), .TW(TW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_dma_cnt (rx_dma_cnt),
  .tx_dma_cnt (tx_dma_cnt),
  .rx_load_wr (rx_load_wr),
  .tx_sm_rd   (tx_sm_rd),
  .reg_addr   (reg_addr),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .ovf_q      (ovf_q),
  .unf_q      (unf_q),
  .rx_lvl_q   (rx_lvl_q),
  .tx_lvl_q   (tx_lvl_q)
);

// File: tb/sim_fifo_stat_regs.sv
module sim_fifo_stat_regs;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 5;
  localparam int TW = 6;
  localparam int DW = 16;
  localparam int NV = 6;

  // {tx_dma, tx_total, rx_dma, rx_total, expected status}; levels at 8
  localparam logic [37:0] VEC [NV] = '{
    {5'd0,  6'd0,  5'd0,  6'd0,  16'h0013},
    {5'd16, 6'd16, 5'd16, 6'd20, 16'h0064},
    {5'd3,  6'd7,  5'd0,  6'd3,  16'h0012},
    {5'd5,  6'd8,  5'd0,  6'd8,  16'h0010},
    {5'd0,  6'd4,  5'd2,  6'd9,  16'h0023},
    {5'd16, 6'd20, 5'd15, 6'd15, 16'h0024}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] tx_dma_cnt, rx_dma_cnt;
  logic [TW-1:0] tx_total_cnt, rx_total_cnt;
  logic          rx_load_wr, tx_sm_rd, reg_wr;
  logic [1:0]    reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_stat_regs u0 (
    .clk (clk), .rst_n (rst_n),
    .tx_dma_cnt (tx_dma_cnt), .tx_total_cnt (tx_total_cnt),
    .rx_dma_cnt (rx_dma_cnt), .rx_total_cnt (rx_total_cnt),
    .rx_load_wr (rx_load_wr), .tx_sm_rd (tx_sm_rd),
    .reg_addr (reg_addr), .reg_wr (reg_wr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // one-cycle register write, returns at the next falling edge
  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    logic [DW-1:0] d;
    rst_n = 1'b0;
    tx_dma_cnt = '0; rx_dma_cnt = '0; tx_total_cnt = '0; rx_total_cnt = '0;
    rx_load_wr = 1'b0; tx_sm_rd = 1'b0; reg_wr = 1'b0;
    reg_addr = 2'd0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk("R1 status", d, 16'h0013);
    rd(2'd1, d); chk("R1 rx level", d, 16'd8);
    rd(2'd2, d); chk("R1 tx level", d, 16'd8);

    // table walk: R2 R3 R4 R5 R12
    for (int i = 0; i < NV; i++) begin
      {tx_dma_cnt, tx_total_cnt, rx_dma_cnt, rx_total_cnt} = VEC[i][37:16];
      rd(2'd0, d);
      chk("R2/R3/R4/R5/R12 vector", d, VEC[i][15:0]);
    end

    // R11 rx data count
    rx_total_cnt = 6'd19;
    rd(2'd3, d); chk("R11 rx count", d, 16'd19);

    // R10 level write: upper data bits dropped
    @(negedge clk);
    wr(2'd1, 16'hFFC3);
    rd(2'd1, d); chk("R10 rx level readback", d, 16'd3);
    tx_dma_cnt = 5'd1; tx_total_cnt = 6'd1; rx_dma_cnt = 5'd1;
    rx_total_cnt = 6'd3;
    rd(2'd0, d); chk("R4 equal not above", d, 16'h0002);
    rx_total_cnt = 6'd4;
    rd(2'd0, d); chk("R4 one above", d, 16'h0022);
    @(negedge clk);
    wr(2'd2, 16'd0);
    rd(2'd2, d); chk("R10 tx level readback", d, 16'd0);
    tx_dma_cnt = 5'd0; tx_total_cnt = 6'd0;
    rd(2'd0, d); chk("R5 zero level never below", d, 16'h0021);
    @(negedge clk);
    wr(2'd1, 16'd8);
    wr(2'd2, 16'd8);

    // R6 overflow: strobe while not full leaves bit clear
    tx_dma_cnt = 5'd4; tx_total_cnt = 6'd9; rx_dma_cnt = 5'd15; rx_total_cnt = 6'd0;
    rx_load_wr = 1'b1;
    @(negedge clk);
    rx_load_wr = 1'b0;
    rd(2'd0, d); chk("R6 no ovf when not full", d & 16'h0300, 16'h0000);
    rx_dma_cnt = 5'd16;
    rx_load_wr = 1'b1;
    @(negedge clk);
    rx_load_wr = 1'b0;
    rd(2'd0, d); chk("R6 ovf set", d & 16'h0300, 16'h0100);
    rx_dma_cnt = 5'd0;
    @(negedge clk);
    rd(2'd0, d); chk("R6 ovf sticky", d & 16'h0300, 16'h0100);

    // R8 write zero leaves, write one clears
    wr(2'd0, 16'h0000);
    rd(2'd0, d); chk("R8 write 0 keeps", d & 16'h0300, 16'h0100);
    wr(2'd0, 16'h0100);
    rd(2'd0, d); chk("R8 write 1 clears", d & 16'h0300, 16'h0000);

    // R7 underflow
    tx_dma_cnt = 5'd0;
    tx_sm_rd = 1'b1;
    @(negedge clk);
    tx_sm_rd = 1'b0;
    rd(2'd0, d); chk("R7 unf set", d & 16'h0300, 16'h0200);
    tx_dma_cnt = 5'd3;
    @(negedge clk);
    rd(2'd0, d); chk("R7 unf sticky", d & 16'h0300, 16'h0200);

    // R9 clear and event in the same cycle: event wins
    tx_dma_cnt = 5'd0;
    tx_sm_rd = 1'b1;
    wr(2'd0, 16'h0200);
    tx_sm_rd = 1'b0;
    rd(2'd0, d); chk("R9 event beats clear", d & 16'h0300, 16'h0200);
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d); chk("R8 clear after", d & 16'h0300, 16'h0000);
    chk("R12 unused bits zero", d & 16'hFC88, 16'h0000);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule